// File: doc/BRIEF.md
# User-Mode Base and Limit Address Guard

This block sits on the path from the effective address generator to the memory bus. Every address it receives is tagged with the processor mode. In user mode the block checks the address against a limit register. That limit counts 256-word chunks. If the address is in range, the block adds a relocation base to form the physical address. If it is not, the block raises a protection trap and the memory request is dropped. In monitor mode the address goes to the bus unchanged.

The block also knows how much memory the machine has fitted, which is a parameter. A user access that passes the limit test but lands above the fitted memory raises a separate trap. A monitor access to missing memory freezes the block, as a machine hang would. The stall flag then stays set until reset, and no further request reaches memory.

Software loads the base and the limit through a small write port. The base always starts on a chunk boundary. A protection violation leaves a sticky flag set, and software clears it with a clear strobe.

Top module: `addr_reloc_guard`

## Requirements
- R1: After reset the base and the limit are zero, and `mem_req`, `trap_prot`, `trap_nxm`, `viol_flag` and `hang` are low. A user-mode access with limit zero therefore raises a protection trap.
- R2: A monitor-mode request (`user_mode`=0) presents `mem_addr` equal to `req_addr`, zero-extended, with `mem_req` high. The limit and the base are ignored.
- R3: A user-mode request that passes the checks presents `mem_addr` = `req_addr` + base, with `mem_req` high.
- R4: A user-mode request for which `req_addr` >> 8 is greater than or equal to the limit raises `trap_prot`, and `mem_req` stays low in that same output cycle. With base 32768 and limit 96, logical 24575 maps to 57343 and logical 24576 traps.
- R5: `viol_flag` is set by every protection trap. It stays set until `viol_clr` is pulsed, and a new violation in the same cycle as a clear wins.
- R6: A base write stores `cfg_wdata` with bits 7:0 forced to zero, so a user access keeps the low 8 address bits unchanged.
- R7: A user-mode request that passes the limit but whose relocated address is at or above `MEM_WORDS` raises `trap_nxm` and not `mem_req`. The protection test takes priority, so an access out of limit raises only `trap_prot`.
- R8: A monitor-mode request at or above `MEM_WORDS` sets `hang`. `hang` stays high until reset, and neither that request nor any later one produces `mem_req` or a trap.
- R9: Results appear exactly one clock after the request cycle. A cycle without `req_valid` yields no `mem_req` and no trap in the next cycle.
- R10: A register write (`cfg_sel`=0 base, 1 limit, limit taken from the low bits of `cfg_wdata`) applies to a request issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | PADDR_W | Register write data |
| viol_clr | input | 1 | Clears the sticky violation flag |
| req_valid | input | 1 | Address request valid |
| user_mode | input | 1 | 1 user mode (checked, relocated), 0 monitor mode |
| req_addr | input | LADDR_W | Logical effective address |
| mem_req | output | 1 | Memory request to the bus |
| mem_addr | output | PADDR_W | Physical address to the bus |
| trap_prot | output | 1 | Protection violation trap pulse |
| trap_nxm | output | 1 | User non-existent memory trap pulse |
| viol_flag | output | 1 | Sticky protection violation flag |
| hang | output | 1 | Monitor non-existent memory stall, held until reset |

## Verification
A wrong base or limit shows up on the first user-mode request after it: the address comes out shifted, or a trap appears where a bus request was due. Either shows one cycle after the request. A corrupted hang or violation state is visible at once on `hang` or `viol_flag`. A false hang also silences every later `mem_req`, so the scoreboard catches it on the next access. Boundary addresses on each side of the limit and of the fitted memory show off-by-one errors in the chunk compare and in the non-existent-memory compare within a single request.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
   // Register select for the configuration write port
   typedef enum logic {
      CFG_BASE  = 1'b0,
      CFG_LIMIT = 1'b1
   } cfg_sel_e;

   // Outcome of one address check, at most one bit set
   typedef struct packed {
      logic pass;    // forward to memory
      logic prot;    // limit violation
      logic nxm;     // user access beyond fitted memory
      logic stall;   // monitor access beyond fitted memory
   } verdict_t;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
   parameter int PADDR_W  = 17,
   parameter int LIM_W    = 10,
   parameter int CHUNK_LG = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [PADDR_W-1:0] cfg_wdata,
   output logic [PADDR_W-1:0] base_q,
   output logic [LIM_W-1:0]   limit_q
);
   import reloc_pkg::*;

   localparam logic [PADDR_W-1:0] ALIGN_MASK = ~((PADDR_W)'((1 << CHUNK_LG) - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_BASE) base_q  <= cfg_wdata & ALIGN_MASK;
         else                     limit_q <= cfg_wdata[LIM_W-1:0];
      end
   end
endmodule

// File: rtl/reloc_check.sv
module reloc_check #(
   parameter int LADDR_W  = 17,
   parameter int PADDR_W  = 17,
   parameter int LIM_W    = 10,
   parameter int CHUNK_LG = 8
) (
   input  logic [LADDR_W-1:0] laddr,
   input  logic [PADDR_W-1:0] base,
   input  logic [LIM_W-1:0]   limit,
   output logic               over_limit,
   output logic [PADDR_W:0]   reloc_sum
);
   localparam int CH_W = LADDR_W - CHUNK_LG;

   logic [CH_W-1:0]  chunk;
   logic [LIM_W-1:0] chunk_ext;

   // Compare chunk index to the chunk count before the base is added
   assign chunk      = laddr[LADDR_W-1:CHUNK_LG];
   assign chunk_ext  = (LIM_W)'(chunk);
   assign over_limit = (chunk_ext >= limit);
   assign reloc_sum  = (PADDR_W+1)'(laddr) + (PADDR_W+1)'(base);
endmodule

// File: rtl/reloc_nxm.sv
module reloc_nxm #(
   parameter int PADDR_W   = 17,
   parameter int MEM_WORDS = 65536
) (
   input  logic [PADDR_W:0] addr,
   output logic             missing
);
   localparam longint FULL = longint'(1) << PADDR_W;
   localparam logic [PADDR_W:0] MEM_TOP = (PADDR_W+1)'(MEM_WORDS);

   generate
      if (longint'(MEM_WORDS) == FULL) begin : g_full_map
         // Every physical address exists; only carry-out is missing
         assign missing = addr[PADDR_W];
      end else begin : g_partial_map
         assign missing = (addr >= MEM_TOP);
      end
   endgenerate
endmodule

// File: rtl/addr_reloc_guard.sv
module addr_reloc_guard #(
   parameter int LADDR_W   = 17,
   parameter int PADDR_W   = 17,
   parameter int CHUNK_LG  = 8,
   parameter int MEM_WORDS = 65536
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [PADDR_W-1:0] cfg_wdata,
   input  logic               viol_clr,
   input  logic               req_valid,
   input  logic               user_mode,
   input  logic [LADDR_W-1:0] req_addr,
   output logic               mem_req,
   output logic [PADDR_W-1:0] mem_addr,
   output logic               trap_prot,
   output logic               trap_nxm,
   output logic               viol_flag,
   output logic               hang
);
   import reloc_pkg::*;

   localparam int LIM_W = LADDR_W - CHUNK_LG + 1;

   // Elaboration-time parameter checks
   if (CHUNK_LG < 1 || CHUNK_LG >= LADDR_W) begin : g_bad_chunk
      $error("CHUNK_LG must lie between 1 and LADDR_W-1");
   end
   if (PADDR_W < LADDR_W) begin : g_bad_paddr
      $error("PADDR_W must be at least LADDR_W");
   end
   if (LIM_W > PADDR_W) begin : g_bad_lim
      $error("limit field does not fit the write port");
   end
   if (MEM_WORDS < 1 || longint'(MEM_WORDS) > (longint'(1) << PADDR_W)) begin : g_bad_mem
      $error("MEM_WORDS out of range for PADDR_W");
   end

   logic [PADDR_W-1:0] base_q;
   logic [LIM_W-1:0]   limit_q;
   logic               over_limit;
   logic [PADDR_W:0]   reloc_sum;
   logic [PADDR_W:0]   phys_sel;
   logic               missing;
   verdict_t           vd;

   logic               mem_req_q, trap_prot_q, trap_nxm_q, viol_q, hang_q;
   logic [PADDR_W-1:0] mem_addr_q;

   reloc_regs #(.PADDR_W(PADDR_W), .LIM_W(LIM_W), .CHUNK_LG(CHUNK_LG)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .base_q   (base_q),
      .limit_q  (limit_q)
   );

   reloc_check #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W), .LIM_W(LIM_W), .CHUNK_LG(CHUNK_LG)) i_check (
      .laddr     (req_addr),
      .base      (base_q),
      .limit     (limit_q),
      .over_limit(over_limit),
      .reloc_sum (reloc_sum)
   );

   // Monitor mode bypasses relocation
   assign phys_sel = user_mode ? reloc_sum : (PADDR_W+1)'(req_addr);

   reloc_nxm #(.PADDR_W(PADDR_W), .MEM_WORDS(MEM_WORDS)) i_nxm (
      .addr   (phys_sel),
      .missing(missing)
   );

   always_comb begin
      vd = '0;
      if (req_valid && !hang_q) begin
         if (user_mode) begin
            if (over_limit)   vd.prot = 1'b1;
            else if (missing) vd.nxm  = 1'b1;
            else              vd.pass = 1'b1;
         end else begin
            if (missing)      vd.stall = 1'b1;
            else              vd.pass  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req_q   <= 1'b0;
         mem_addr_q  <= '0;
         trap_prot_q <= 1'b0;
         trap_nxm_q  <= 1'b0;
         viol_q      <= 1'b0;
         hang_q      <= 1'b0;
      end else begin
         mem_req_q   <= vd.pass;
         trap_prot_q <= vd.prot;
         trap_nxm_q  <= vd.nxm;
         if (vd.pass) mem_addr_q <= phys_sel[PADDR_W-1:0];
         if (vd.prot)      viol_q <= 1'b1;
         else if (viol_clr) viol_q <= 1'b0;
         if (vd.stall) hang_q <= 1'b1;
      end
   end

   assign mem_req   = mem_req_q;
   assign mem_addr  = mem_addr_q;
   assign trap_prot = trap_prot_q;
   assign trap_nxm  = trap_nxm_q;
   assign viol_flag = viol_q;
   assign hang      = hang_q;
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
   parameter int LADDR_W = 17,
   parameter int PADDR_W = 17
) (
   input logic               clk,
   input logic               rst_n,
   input logic               viol_clr,
   input logic               req_valid,
   input logic               user_mode,
   input logic [LADDR_W-1:0] req_addr,
   input logic               mem_req,
   input logic [PADDR_W-1:0] mem_addr,
   input logic               trap_prot,
   input logic               trap_nxm,
   input logic               viol_flag,
   input logic               hang
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, trap_prot, trap_nxm}));                          // R4

   AST_TRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trap_prot |-> viol_flag);                                           // R5

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flag && !viol_clr) |=> viol_flag);                            // R5

   AST_MON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !$past(user_mode)) |-> (mem_addr == (PADDR_W)'($past(req_addr))));  // R2

   AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(user_mode)) |-> (mem_addr[7:0] == $past(req_addr[7:0])));   // R6

   AST_HANG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      hang |=> hang);                                                     // R8

   AST_HANG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      hang |-> !(mem_req || trap_prot || trap_nxm));                      // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> !(mem_req || trap_prot || trap_nxm));         // R9
endmodule

bind addr_reloc_guard reloc_guard_chk #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .viol_clr (viol_clr),
   .req_valid(req_valid),
   .user_mode(user_mode),
   .req_addr (req_addr),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .trap_prot(trap_prot),
   .trap_nxm (trap_nxm),
   .viol_flag(viol_flag),
   .hang     (hang)
);

// File: tb/test_addr_reloc_guard.sv
`timescale 1ns/1ps
module test_addr_reloc_guard;
   localparam int LW = 17;
   localparam int PW = 17;
   localparam int MEMW = 65536;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [PW-1:0] cfg_wdata = '0;
   logic          viol_clr = 1'b0;
   logic          req_valid = 1'b0;
   logic          user_mode = 1'b0;
   logic [LW-1:0] req_addr = '0;
   logic          mem_req, trap_prot, trap_nxm, viol_flag, hang;
   logic [PW-1:0] mem_addr;

   always #2.5 clk = ~clk;

   addr_reloc_guard #(.LADDR_W(LW), .PADDR_W(PW), .CHUNK_LG(8), .MEM_WORDS(MEMW)) i_addr_reloc_guard (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .viol_clr(viol_clr), .req_valid(req_valid), .user_mode(user_mode), .req_addr(req_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .trap_prot(trap_prot), .trap_nxm(trap_nxm),
      .viol_flag(viol_flag), .hang(hang)
   );

   typedef struct {
      logic  req;
      int    addr;
      logic  tp;
      logic  tn;
      string rq;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   // Reference state, from the requirements
   int   m_base = 0;
   int   m_limit = 0;
   bit   m_hang = 0;

   task automatic chk(bit ok, string rq, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic load(bit sel, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = PW'(data);
      if (!sel) m_base = data & ~255;
      else      m_limit = data & 1023;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Driver: one request, expectation pushed to the scoreboard
   task automatic issue(bit um, int la, string rq);
      exp_t e;
      int sum;
      e.req = 0; e.addr = 0; e.tp = 0; e.tn = 0; e.rq = rq;
      if (!m_hang) begin
         if (um) begin
            if ((la >> 8) >= m_limit) e.tp = 1;
            else begin
               sum = la + m_base;
               if (sum >= MEMW) e.tn = 1;
               else begin e.req = 1; e.addr = sum; end
            end
         end else begin
            if (la >= MEMW) m_hang = 1;
            else begin e.req = 1; e.addr = la; end
         end
      end
      @(negedge clk);
      req_valid = 1'b1; user_mode = um; req_addr = LW'(la);
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: compares each result one clock after its request
   initial begin
      forever begin
         bit fired;
         exp_t e;
         @(posedge clk);
         fired = (req_valid === 1'b1) && (rst_n === 1'b1);
         #1;
         if (fired) begin
            if (sb.size() == 0) chk(0, "R9", "unexpected result", 1, 0);
            else begin
               e = sb.pop_front();
               chk(mem_req === e.req, e.rq, "mem_req", int'(mem_req), int'(e.req));
               chk(trap_prot === e.tp, e.rq, "trap_prot", int'(trap_prot), int'(e.tp));
               chk(trap_nxm === e.tn, e.rq, "trap_nxm", int'(trap_nxm), int'(e.tn));
               if (e.req) chk(int'(mem_addr) == e.addr, e.rq, "mem_addr", int'(mem_addr), e.addr);
            end
         end else if (rst_n === 1'b1) begin
            chk(!(mem_req || trap_prot || trap_nxm), "R9", "idle output",
                int'({mem_req, trap_prot, trap_nxm}), 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req && !trap_prot && !trap_nxm, "R1", "outputs after reset",
          int'({mem_req, trap_prot, trap_nxm}), 0);
      chk(viol_flag == 0 && hang == 0, "R1", "flags after reset", int'({viol_flag, hang}), 0);
      issue(1, 0, "R1");                       // limit 0: trap
      chk(viol_flag == 1, "R5", "flag after trap", int'(viol_flag), 1);
      repeat (3) @(negedge clk);
      chk(viol_flag == 1, "R5", "flag holds", int'(viol_flag), 1);
      viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
      chk(viol_flag == 0, "R5", "flag cleared", int'(viol_flag), 0);

      // R2 monitor pass-through ignores limit/base
      issue(0, 5, "R2");
      issue(0, 40000, "R2");
      issue(0, 65535, "R2");

      // R4/R3 worked example: base 32K, limit 24K/256
      load(0, 32768);
      load(1, 96);
      issue(1, 0, "R3");
      issue(1, 1234, "R3");
      issue(1, 24575, "R4");
      issue(1, 24576, "R4");
      issue(1, 131071, "R4");
      issue(0, 300, "R2");
      // R5 violation and clear in same cycle: set wins
      viol_clr = 1'b1;
      issue(1, 30000, "R5");
      viol_clr = 1'b0;
      chk(viol_flag == 1, "R5", "set beats clear", int'(viol_flag), 1);
      viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
      chk(viol_flag == 0, "R5", "cleared again", int'(viol_flag), 0);

      // R6 base alignment
      load(0, 'h4123);
      issue(1, 'h00AB, "R6");
      // R10 write then immediate request
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = PW'(1);
      m_limit = 1;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b1; user_mode = 1'b1; req_addr = LW'(256);
      begin
         exp_t e;
         e.req = 0; e.addr = 0; e.tp = 1; e.tn = 0; e.rq = "R10";
         sb.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b0;
      issue(1, 255, "R10");

      // R7 user non-existent memory: base 48K, limit 96
      load(0, 49152);
      load(1, 96);
      issue(1, 16383, "R7");
      issue(1, 16384, "R7");
      issue(1, 20000, "R7");
      issue(1, 24576, "R7");                   // prot takes priority
      chk(hang == 0, "R7", "no hang in user mode", int'(hang), 0);

      // Back-to-back requests
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         exp_t e;
         e.req = 1; e.addr = 49152 + i * 100; e.tp = 0; e.tn = 0; e.rq = "R9";
         req_valid = 1'b1; user_mode = 1'b1; req_addr = LW'(i * 100);
         sb.push_back(e);
         @(negedge clk);
      end
      req_valid = 1'b0;

      // R8 monitor hang
      issue(0, 70000, "R8");
      chk(hang == 1, "R8", "hang set", int'(hang), 1);
      issue(0, 10, "R8");
      issue(1, 10, "R8");
      repeat (3) @(negedge clk);
      chk(hang == 1, "R8", "hang held", int'(hang), 1);

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_hang = 0; m_base = 0; m_limit = 0;
      @(negedge clk);
      chk(hang == 0, "R1", "hang cleared by reset", int'(hang), 0);
      issue(0, 77, "R2");

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule